// File: doc/BRIEF.md
# EPR4 Maximum-Likelihood Sequence Detector

This block sits after the equalizer of a magnetic read channel. Each bit period it may take one signed 6-bit sample, shaped to the response 1 + D − D² − D³. It returns the most likely written bit sequence. A noiseless sample depends on the newest bit and the three bits before it, so the detector runs an 8-state trellis. Each state holds the last three bits.

The datapath has three parts. A branch-metric stage scores the sample against the five possible ideal levels using squared distance. An add-compare-select array updates eight unsigned, saturating path metrics and pulls the smallest one back to zero on every accepted sample. A register-exchange survivor memory keeps DEPTH bits per state. Bits leave from the oldest end of the best state's path, so every decision sees DEPTH−1 later samples before it is final.

A two-state controller decides when output starts. Reset puts it in ST_FILL. The transition fill_done moves it to ST_RUN on the edge that accepts sample DEPTH−2, counting from 0. From then on, every accepted sample pushes out one detected bit. Only reset leaves ST_RUN.

Top module: `vit_epr4_det`

## Requirements
- R1: While reset is high, and in the cycle after it, out_valid and dout are both 0.
- R2: Bits map to symbols a = +1 for 1 and −1 for 0. The ideal sample for bit k is STEP·(a_k + a_{k−1} − a_{k−2} − a_{k−3}), with STEP = 6 by default. Samples are two's complement. All 16 four-bit histories are detected without error when fed noiselessly.
- R3: For a noiseless random bit stream, the detected sequence equals the sent sequence bit for bit.
- R4: If every sample carries additive noise of magnitude at most 2 counts, the detected sequence still equals the sent sequence.
- R5: Counting accepted samples from 0 after reset, detected bit j is output with out_valid high in the cycle after the edge that accepts sample j+DEPTH−1. out_valid stays low until that edge for j = 0.
- R6: A cycle with in_valid low changes no path metric and no survivor. It also produces no output. out_valid is high only in the cycle after an accepting edge.
- R7: After every accepted sample, the smallest path metric is 0 and no path metric sits at its saturation value. Detection resumes correctly after a long stretch of out-of-model full-scale samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is offered this cycle |
| in_sample | input | SAMPLE_W | Equalized sample, two's complement |
| out_valid | output | 1 | dout holds a detected bit this cycle |
| dout | output | 1 | Detected bit, oldest first |

## Verification
The assertions assume the samples come from the stated 8-state model with modest noise. Under that assumption the spread between path metrics stays far below the metric width, so saturation never triggers. They also assume in_valid is 0 or 1 at every edge after reset, because the fill count is kept in the checker. The stimulus builds each sample from the exact level formula with noise bounded to ±2. It then clamps the result to the 6-bit range. The one departure is a deliberate full-scale stretch. Since no state can reach a metric much worse than the best within three steps, metrics stay bounded even there. Bits whose decisions overlap that stretch are excluded from comparison.

// File: rtl/vit_epr4_pkg.sv
package vit_epr4_pkg;

    // channel memory of the 1 + D - D^2 - D^3 response
    localparam int MEM    = 3;
    localparam int NSTATE = 1 << MEM;
    localparam int NLEVEL = 5;

    typedef enum logic {ST_FILL, ST_RUN} det_state_e;

    // symbol of one stored bit
    function automatic int sym(input int b);
        return (b != 0) ? 1 : -1;
    endfunction

    // history word h: bit3 newest input, bit0 oldest; returns level index 0..4
    function automatic int level_index(input int h);
        int y;
        y = sym((h >> 3) & 1) + sym((h >> 2) & 1) - sym((h >> 1) & 1) - sym(h & 1);
        return (y + 4) / 2;
    endfunction

endpackage

// File: rtl/vit_bmu.sv
module vit_bmu #(
    parameter int SAMPLE_W = 6,
    parameter int STEP     = 6,
    parameter int DW       = SAMPLE_W + 3,
    parameter int BM_W     = 2 * DW
) (
    input  logic signed [SAMPLE_W-1:0]                  sample,
    output logic        [vit_epr4_pkg::NLEVEL-1:0][BM_W-1:0] lvl_metric
);
    for (genvar g = 0; g < vit_epr4_pkg::NLEVEL; g++) begin : g_level
        localparam int IDEAL = (2 * g - 4) * STEP;
        logic signed [DW-1:0]   diff;
        logic signed [2*DW-1:0] sq;
        assign diff = DW'(sample) - DW'(IDEAL);
        assign sq   = diff * diff;
        assign lvl_metric[g] = BM_W'($unsigned(sq));
    end
endmodule

// File: rtl/vit_acs_array.sv
module vit_acs_array #(
    parameter int BM_W = 18,
    parameter int PM_W = 20
) (
    input  logic [vit_epr4_pkg::NSTATE-1:0][PM_W-1:0] pm_cur,
    input  logic [vit_epr4_pkg::NLEVEL-1:0][BM_W-1:0] lvl_metric,
    output logic [vit_epr4_pkg::NSTATE-1:0][PM_W-1:0] pm_norm,
    output logic [vit_epr4_pkg::NSTATE-1:0]           dec,
    output logic [vit_epr4_pkg::MEM-1:0]              best
);
    import vit_epr4_pkg::*;

    logic [NSTATE-1:0][PM_W-1:0] surv;

    for (genvar s = 0; s < NSTATE; s++) begin : g_state
        localparam int P0 = (2 * s) % NSTATE;
        localparam int L0 = level_index(2 * s);
        localparam int L1 = level_index(2 * s + 1);
        logic [PM_W:0]   sum0, sum1;
        logic [PM_W-1:0] cand0, cand1;
        assign sum0  = {1'b0, pm_cur[P0]}     + (PM_W+1)'(lvl_metric[L0]);
        assign sum1  = {1'b0, pm_cur[P0 + 1]} + (PM_W+1)'(lvl_metric[L1]);
        assign cand0 = sum0[PM_W] ? '1 : sum0[PM_W-1:0];
        assign cand1 = sum1[PM_W] ? '1 : sum1[PM_W-1:0];
        assign dec[s]  = cand1 < cand0;
        assign surv[s] = dec[s] ? cand1 : cand0;
    end

    logic [PM_W-1:0] min_pm;
    always_comb begin
        min_pm = surv[0];
        best   = '0;
        for (int s = 1; s < NSTATE; s++) begin
            if (surv[s] < min_pm) begin
                min_pm = surv[s];
                best   = MEM'(s);
            end
        end
        for (int s = 0; s < NSTATE; s++) begin
            pm_norm[s] = surv[s] - min_pm;
        end
    end
endmodule

// File: rtl/vit_survivor.sv
module vit_survivor #(
    parameter int DEPTH = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             en,
    input  logic [vit_epr4_pkg::NSTATE-1:0]  dec,
    input  logic [vit_epr4_pkg::MEM-1:0]     best,
    output logic                             head_bit
);
    import vit_epr4_pkg::*;

    logic [NSTATE-1:0][DEPTH-1:0] path_q;
    logic [NSTATE-1:0][DEPTH-1:0] path_d;

    for (genvar s = 0; s < NSTATE; s++) begin : g_path
        localparam int  P0   = (2 * s) % NSTATE;
        localparam logic NEWB = 1'((s >> (MEM - 1)) & 1);
        logic [MEM-1:0] pred;
        assign pred      = MEM'(P0) | MEM'(dec[s]);
        assign path_d[s] = {path_q[pred][DEPTH-2:0], NEWB};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            path_q <= '0;
        end else if (en) begin
            path_q <= path_d;
        end
    end

    assign head_bit = path_d[best][DEPTH-1];
endmodule

// File: rtl/vit_epr4_det.sv
module vit_epr4_det #(
    parameter int SAMPLE_W = 6,
    parameter int STEP     = 6,
    parameter int PM_W     = 20,
    parameter int DEPTH    = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    output logic                       out_valid,
    output logic                       dout
);
    import vit_epr4_pkg::*;

    localparam int DW    = SAMPLE_W + 3;
    localparam int BM_W  = 2 * DW;
    localparam int CNT_W = $clog2(DEPTH);

    det_state_e  state_q, state_d;
    logic [CNT_W-1:0] fill_q, fill_d;

    logic [NLEVEL-1:0][BM_W-1:0] lvl_metric;
    logic [NSTATE-1:0][PM_W-1:0] pm_q, pm_norm;
    logic [NSTATE-1:0]           dec;
    logic [MEM-1:0]              best;
    logic                        head_bit;

    vit_bmu #(.SAMPLE_W(SAMPLE_W), .STEP(STEP), .DW(DW), .BM_W(BM_W)) u_bmu (
        .sample(in_sample), .lvl_metric(lvl_metric));

    vit_acs_array #(.BM_W(BM_W), .PM_W(PM_W)) u_acs (
        .pm_cur(pm_q), .lvl_metric(lvl_metric),
        .pm_norm(pm_norm), .dec(dec), .best(best));

    vit_survivor #(.DEPTH(DEPTH)) u_surv (
        .clk(clk), .rst(rst), .en(in_valid),
        .dec(dec), .best(best), .head_bit(head_bit));

    always_ff @(posedge clk) begin
        if (rst) begin
            pm_q <= '0;
        end else if (in_valid) begin
            pm_q <= pm_norm;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        if (in_valid) begin
            unique case (state_q)
                ST_FILL: begin
                    fill_d = fill_q + 1'b1;
                    if (fill_q == CNT_W'(DEPTH - 2)) state_d = ST_RUN;
                end
                ST_RUN: state_d = ST_RUN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dout      <= 1'b0;
        end else begin
            out_valid <= in_valid && (state_q == ST_RUN);
            if (in_valid && (state_q == ST_RUN)) dout <= head_bit;
        end
    end
endmodule

// File: rtl/vit_epr4_det_chk.sv
module vit_epr4_det_chk #(
    parameter int NSTATE = 8,
    parameter int PM_W   = 20,
    parameter int DEPTH  = 32
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        in_valid,
    input logic                        out_valid,
    input logic                        dout,
    input logic [NSTATE-1:0][PM_W-1:0] pm
);
    localparam int AW = $clog2(DEPTH + 1);

    logic [AW-1:0] acc_cnt;
    always_ff @(posedge clk) begin
        if (rst) acc_cnt <= '0;
        else if (in_valid && acc_cnt != AW'(DEPTH)) acc_cnt <= acc_cnt + 1'b1;
    end

    logic has_zero, any_full;
    always_comb begin
        has_zero = 1'b0;
        any_full = 1'b0;
        for (int s = 0; s < NSTATE; s++) begin
            if (pm[s] == '0) has_zero = 1'b1;
            if (pm[s] == '1) any_full = 1'b1;
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!out_valid && !dout));
    // R5
    a_r5_quiet_fill: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (acc_cnt == AW'(DEPTH)));
    // R6
    a_r6_out_needs_accept: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(pm) && !out_valid));
    // R7
    a_r7_norm_zero: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> has_zero);
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> !any_full);
endmodule

bind vit_epr4_det vit_epr4_det_chk #(.NSTATE(NSTATE), .PM_W(PM_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .dout(dout), .pm(pm_q));

// File: tb/vit_epr4_det_tb.sv
`timescale 1ns/1ps
module vit_epr4_det_tb;
    localparam int SAMPLE_W = 6;
    localparam int STEP     = 6;
    localparam int DEPTH    = 32;
    localparam int MAXS     = 8192;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [SAMPLE_W-1:0] in_sample = '0;
    logic out_valid, dout;

    vit_epr4_det #(.SAMPLE_W(SAMPLE_W), .STEP(STEP), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .dout(dout));

    always #4 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    bit sent_bits [MAXS];
    bit care      [MAXS];
    int sent = 0;
    int acc_cnt = 0, out_cnt = 0;
    int mism = 0, vbad = 0, lat_bad = 0;
    int skip_left = 0;
    bit h2 = 0, h1 = 0, h0 = 0;
    bit done = 0;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sy(input bit b);
        return b ? 1 : -1;
    endfunction

    // monitor: away from the edge, counts accepted samples and judges outputs
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (in_valid) acc_cnt++;
            if (out_valid !== (in_valid && acc_cnt >= DEPTH)) vbad++;
            if (out_valid) begin
                if (acc_cnt != out_cnt + DEPTH) lat_bad++;
                if (care[out_cnt] && dout !== sent_bits[out_cnt]) mism++;
                out_cnt++;
            end
        end
    end

    task automatic send(input bit b, input int noise, input bit rail);
        int v;
        @(negedge clk);
        v = STEP * (sy(b) + sy(h2) - sy(h1) - sy(h0)) + noise;
        if (rail) v = 31;
        if (v > 31) v = 31;
        if (v < -32) v = -32;
        in_valid  = 1'b1;
        in_sample = SAMPLE_W'(v);
        sent_bits[sent] = b;
        care[sent] = !rail && (skip_left == 0);
        if (skip_left > 0 && !rail) skip_left--;
        sent++;
        h0 = h1; h1 = h2; h2 = b;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid  = 1'b0;
        in_sample = ($urandom_range(0, 1) != 0) ? SAMPLE_W'(31) : SAMPLE_W'(-32);
    endtask

    task automatic flush();
        for (int i = 0; i < DEPTH; i++) send(1'($urandom_range(0, 1)), 0, 1'b0);
        idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 dout in reset", int'(dout), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid after reset", int'(out_valid), 0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < DEPTH - 1; i++) send(1'($urandom_range(0, 1)), 0, 1'b0);
        idle();
        @(negedge clk);
        check("R5 no output before fill", out_cnt, 0);
        send(1'($urandom_range(0, 1)), 0, 1'b0);
        idle();
        @(negedge clk);
        check("R5 first bit after DEPTH samples", out_cnt, 1);
        check("R5 latency errors", lat_bad, 0);
    endtask

    task automatic t_patterns();
        int m0 = mism;
        for (int rep = 0; rep < 4; rep++)
            for (int h = 0; h < 16; h++)
                for (int k = 3; k >= 0; k--) send(1'((h >> k) & 1), 0, 1'b0);
        flush();
        check("R2 all histories detected", mism - m0, 0);
    endtask

    task automatic t_clean();
        int m0 = mism;
        for (int i = 0; i < 600; i++) send(1'($urandom_range(0, 1)), 0, 1'b0);
        flush();
        check("R3 noiseless mismatches", mism - m0, 0);
        check("R3 every accepted sample yields a bit", out_cnt, acc_cnt - DEPTH + 1);
    endtask

    task automatic t_noise();
        int m0 = mism;
        for (int i = 0; i < 800; i++)
            send(1'($urandom_range(0, 1)), $urandom_range(0, 4) - 2, 1'b0);
        flush();
        check("R4 bounded-noise mismatches", mism - m0, 0);
    endtask

    task automatic t_gaps();
        int m0 = mism, v0 = vbad;
        for (int i = 0; i < 500; i++) begin
            if ($urandom_range(0, 2) == 0)
                for (int g = 0; g < int'($urandom_range(1, 3)); g++) idle();
            send(1'($urandom_range(0, 1)), 0, 1'b0);
        end
        flush();
        check("R6 mismatches with idle gaps", mism - m0, 0);
        check("R6 out_valid only after accepting edge", vbad - v0, 0);
    endtask

    task automatic t_rail();
        int m0, v0 = vbad;
        for (int i = 1; i <= DEPTH; i++) care[sent - i] = 1'b0;
        for (int i = 0; i < 300; i++) send(1'($urandom_range(0, 1)), 0, 1'b1);
        skip_left = 64;
        m0 = mism;
        for (int i = 0; i < 400; i++) send(1'($urandom_range(0, 1)), 0, 1'b0);
        flush();
        check("R7 recovery after full-scale stretch", mism - m0, 0);
        check("R7 outputs continue through stretch", vbad - v0, 0);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        t_reset();
        t_fill();
        t_patterns();
        t_clean();
        t_noise();
        t_gaps();
        t_rail();
        check("R5 latency over whole run", lat_bad, 0);
        check("R6 out_valid pattern over whole run", vbad, 0);
        report();
    end
endmodule